// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two thresholds used by a FIFO's programmable flags: the empty offset, used by the almost-empty flag, and the full offset, used by the almost-full flag. While master reset is held, the block samples three pins. Two select pins and the access pin pick one of eight preset threshold pairs. The access pin also fixes how the thresholds can be changed once reset is released: either bit by bit through a serial input, or word by word through the data bus with word readback. A separate dual-use pin reports the FIFO mode during reset and serves as the serial data input afterwards.

After reset, driving the access pin low opens the offset registers to writes and reads. While it is low, normal FIFO transfers are blocked. The FIFO storage is outside this block. The block only presents the two offsets, the latched mode bits, a load-active indication and a transfer-enable indication.

Top module: `flag_offset_prog`

## Requirements
- R1: On each clock edge with `rst_n` low, both offsets are loaded with 2^(k+3)-1, where k = {flag_sel[1], flag_sel[0], ofs_access_n} read as a 3-bit number (giving 7 up to 1023). The new values are visible after that edge.
- R2: `parallel_mode` takes the value of `!ofs_access_n` at every clock edge with `rst_n` low, and it holds that value while `rst_n` is high. A value of 1 selects word programming and 0 selects serial programming.
- R3: `first_word_mode` takes the value of `mode_si` at every clock edge with `rst_n` low, and it holds that value while `rst_n` is high.
- R4: `xfer_en` equals `rst_n & ofs_access_n` and `load_active` equals `rst_n & !ofs_access_n`, both combinationally. FIFO transfers are therefore blocked while the access pin is low or while reset is held.
- R5: In serial mode, each clock edge with `load_active` and `wr_en` high stores `mode_si` into one offset bit. Bits 0 to OFS_W-1 of the empty offset are filled first, least significant bit first. Bits 0 to OFS_W-1 of the full offset follow. After the last full bit, the next shift goes to empty bit 0 again.
- R6: In word mode, each edge with `load_active` and `wr_en` high stores `data_in` into one offset. The empty and full offsets alternate, starting with the empty offset.
- R7: In word mode, each edge with `load_active` and `rd_en` high places one offset on `ofs_rdata` after that edge. The empty and full offsets alternate, starting with the empty offset. This read pointer advances independently of writes. A read in the same cycle as a write returns the value held before that write.
- R8: `wr_en` and `rd_en` have no effect on the offsets or on `ofs_rdata` while `ofs_access_n` is high. `rd_en` has no effect on `ofs_rdata` in serial mode.
- R9: A master reset clears `ofs_rdata` to 0. It returns the serial bit position to empty bit 0, and it returns both word pointers to the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Master reset, active low, sampled on clk |
| flag_sel | input | 2 | Preset selector, sampled during reset |
| ofs_access_n | input | 1 | During reset: selects the preset and the programming method. Afterwards: opens offset access when low |
| mode_si | input | 1 | During reset: FIFO mode select. Afterwards: serial offset data |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| data_in | input | OFS_W | Word for word-mode offset writes |
| empty_ofs | output | OFS_W | Current empty offset |
| full_ofs | output | OFS_W | Current full offset |
| ofs_rdata | output | OFS_W | Word-mode readback |
| parallel_mode | output | 1 | 1 = word programming, 0 = serial |
| first_word_mode | output | 1 | Latched FIFO mode bit |
| load_active | output | 1 | Offset access is open |
| xfer_en | output | 1 | FIFO data transfers are allowed |

## Verification
The offsets, the readback word and the mode bits are all registered. Each reflects the inputs sampled at one rising edge and is valid from that edge until the next one. `xfer_en` and `load_active` follow the pins in the same cycle. The bench drives inputs on the falling edge. It updates a behavioural model on the rising edge from the same inputs, and at the following falling edge it compares every output with the model. A registered result is therefore checked one edge after its stimulus, and a combinational result is checked in the cycle its inputs were applied.

// File: rtl/fop_pkg.sv
package fop_pkg;
  // Target of a word-mode access; order fixes the sequence empty -> full.
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;

  localparam int unsigned PRESET_COUNT   = 8;
  localparam int unsigned PRESET_MIN_EXP = 3;

  function automatic ofs_sel_e next_sel(input ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/fop_cfg_latch.sv
module fop_cfg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ofs_access_n,
  input  logic mode_si,
  output logic parallel_mode,
  output logic first_word_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parallel_mode   <= ~ofs_access_n;
      first_word_mode <= mode_si;
    end
  end

  // R2 / R3: configuration is frozen once reset is released
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(parallel_mode));
  assert_fwft_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(first_word_mode));
endmodule

// File: rtl/fop_serial_loader.sv
module fop_serial_loader #(
  parameter int unsigned OFS_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_go,
  output logic                       bit_we,
  output fop_pkg::ofs_sel_e          bit_sel,
  output logic [$clog2(OFS_W)-1:0]   bit_idx
);
  import fop_pkg::*;
  localparam int unsigned TOTAL = 2 * OFS_W;
  localparam int unsigned CNT_W = $clog2(TOTAL);
  localparam int unsigned IDX_W = $clog2(OFS_W);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == CNT_W'(TOTAL - 1));
  assign bit_we  = shift_go;
  assign bit_sel = (cnt >= CNT_W'(OFS_W)) ? SEL_FULL : SEL_EMPTY;
  assign bit_idx = (bit_sel == SEL_FULL) ? IDX_W'(cnt - CNT_W'(OFS_W)) : IDX_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (shift_go) cnt <= at_last ? '0 : cnt + 1'b1;
  end

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_go && at_last |=> cnt == '0);
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(TOTAL));
endmodule

// File: rtl/fop_word_port.sv
module fop_word_port #(
  parameter int unsigned OFS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [OFS_W-1:0]  data_in,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic              word_we,
  output fop_pkg::ofs_sel_e word_sel,
  output logic [OFS_W-1:0]  word_val,
  output logic [OFS_W-1:0]  rdata
);
  import fop_pkg::*;
  ofs_sel_e wptr, rptr;

  assign word_we  = wr_go;
  assign word_sel = wptr;
  assign word_val = data_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= SEL_EMPTY;
      rptr  <= SEL_EMPTY;
      rdata <= '0;
    end else begin
      if (wr_go) wptr <= next_sel(wptr);
      if (rd_go) begin
        rdata <= (rptr == SEL_FULL) ? full_ofs : empty_ofs;
        rptr  <= next_sel(rptr);
      end
    end
  end

  // R8: readback word only moves on a qualified read
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rdata));
endmodule

// File: rtl/fop_offset_regs.sv
module fop_offset_regs #(
  parameter int unsigned OFS_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                preset_idx,
  input  logic                      bit_we,
  input  fop_pkg::ofs_sel_e         bit_sel,
  input  logic [$clog2(OFS_W)-1:0]  bit_idx,
  input  logic                      bit_val,
  input  logic                      word_we,
  input  fop_pkg::ofs_sel_e         word_sel,
  input  logic [OFS_W-1:0]          word_val,
  output logic [OFS_W-1:0]          empty_ofs,
  output logic [OFS_W-1:0]          full_ofs
);
  import fop_pkg::*;

  function automatic logic [OFS_W-1:0] preset_value(input logic [2:0] k);
    return OFS_W'((1 << (int'(k) + PRESET_MIN_EXP)) - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_ofs <= preset_value(preset_idx);
      full_ofs  <= preset_value(preset_idx);
    end else if (word_we) begin
      if (word_sel == SEL_EMPTY) empty_ofs <= word_val;
      else                       full_ofs  <= word_val;
    end else if (bit_we) begin
      if (bit_sel == SEL_EMPTY) empty_ofs[bit_idx] <= bit_val;
      else                      full_ofs[bit_idx]  <= bit_val;
    end
  end

  assert_preset_R1: assert property (@(posedge clk)
    !rst_n |=> (empty_ofs == preset_value($past(preset_idx))) && (full_ofs == empty_ofs));
  assert_word_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_we && word_sel == SEL_EMPTY |=> empty_ofs == $past(word_val) && $stable(full_ofs));
  assert_bit_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we && !word_we && bit_sel == SEL_FULL |=> full_ofs[$past(bit_idx)] == $past(bit_val) && $stable(empty_ofs));
endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog #(
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       flag_sel,
  input  logic             ofs_access_n,
  input  logic             mode_si,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] data_in,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic [OFS_W-1:0] ofs_rdata,
  output logic             parallel_mode,
  output logic             first_word_mode,
  output logic             load_active,
  output logic             xfer_en
);
  import fop_pkg::*;
  localparam int unsigned IDX_W = $clog2(OFS_W);

  logic [2:0]        preset_idx;
  logic              shift_go, wr_go, rd_go;
  logic              bit_we, word_we;
  ofs_sel_e          bit_sel, word_sel;
  logic [IDX_W-1:0]  bit_idx;
  logic [OFS_W-1:0]  word_val;

  assign preset_idx  = {flag_sel, ofs_access_n};
  assign load_active = rst_n & ~ofs_access_n;
  assign xfer_en     = rst_n &  ofs_access_n;
  assign shift_go    = load_active & wr_en & ~parallel_mode;
  assign wr_go       = load_active & wr_en &  parallel_mode;
  assign rd_go       = load_active & rd_en &  parallel_mode;

  fop_cfg_latch u_cfg (
    .clk, .rst_n, .ofs_access_n, .mode_si,
    .parallel_mode, .first_word_mode
  );

  fop_serial_loader #(.OFS_W(OFS_W)) u_ser (
    .clk, .rst_n, .shift_go, .bit_we, .bit_sel, .bit_idx
  );

  fop_word_port #(.OFS_W(OFS_W)) u_word (
    .clk, .rst_n, .wr_go, .rd_go, .data_in, .empty_ofs, .full_ofs,
    .word_we, .word_sel, .word_val, .rdata(ofs_rdata)
  );

  fop_offset_regs #(.OFS_W(OFS_W)) u_regs (
    .clk, .rst_n, .preset_idx, .bit_we, .bit_sel, .bit_idx, .bit_val(mode_si),
    .word_we, .word_sel, .word_val, .empty_ofs, .full_ofs
  );

  // R8: with access closed the thresholds cannot move
  assert_closed_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_access_n |=> $stable(empty_ofs) && $stable(full_ofs));
  // R4: transfers and offset access never open together
  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_en && (shift_go || wr_go || rd_go)));
endmodule

// File: tb/sim_flag_offset_prog.sv
module sim_flag_offset_prog;
  localparam int W = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [1:0]   flag_sel = 2'd0;
  logic         ofs_access_n = 1'b1;
  logic         mode_si = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] empty_ofs, full_ofs, ofs_rdata;
  logic         parallel_mode, first_word_mode, load_active, xfer_en;

  flag_offset_prog #(.OFS_W(W)) u0 (
    .clk, .rst_n, .flag_sel, .ofs_access_n, .mode_si, .wr_en, .rd_en, .data_in,
    .empty_ofs, .full_ofs, .ofs_rdata, .parallel_mode, .first_word_mode,
    .load_active, .xfer_en
  );

  // behavioural reference
  logic [W-1:0] m_empty, m_full, m_rdata;
  bit m_par, m_fwft;
  int m_cnt, m_wp, m_rp;
  int vectors = 0, fails = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      int k;
      k = flag_sel * 2 + int'(ofs_access_n);
      m_empty = W'((1 << (k + 3)) - 1);
      m_full  = m_empty;
      m_par = !ofs_access_n; m_fwft = mode_si;
      m_cnt = 0; m_wp = 0; m_rp = 0; m_rdata = '0;
    end else if (!ofs_access_n) begin
      if (rd_en && m_par) begin
        m_rdata = (m_rp == 1) ? m_full : m_empty;
        m_rp ^= 1;
      end
      if (wr_en) begin
        if (m_par) begin
          if (m_wp == 0) m_empty = data_in; else m_full = data_in;
          m_wp ^= 1;
        end else begin
          if (m_cnt < W) m_empty[m_cnt] = mode_si; else m_full[m_cnt - W] = mode_si;
          m_cnt = (m_cnt + 1) % (2 * W);
        end
      end
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp(cur_req, "empty_ofs", int'(empty_ofs), int'(m_empty));
    cmp(cur_req, "full_ofs", int'(full_ofs), int'(m_full));
    cmp(cur_req, "ofs_rdata", int'(ofs_rdata), int'(m_rdata));
    cmp("R2", "parallel_mode", int'(parallel_mode), int'(m_par));
    cmp("R3", "first_word_mode", int'(first_word_mode), int'(m_fwft));
    cmp("R4", "xfer_en", int'(xfer_en), int'(rst_n && ofs_access_n));
    cmp("R4", "load_active", int'(load_active), int'(rst_n && !ofs_access_n));
  endtask

  task automatic do_reset(int sel, bit acc_n, bit si);
    rst_n = 0; flag_sel = 2'(sel); ofs_access_n = acc_n; mode_si = si;
    wr_en = 0; rd_en = 0;
    cyc(); cyc();
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1, R2, R3: every preset and both reset-time modes
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      cur_req = "R1";
      do_reset(k / 2, bit'(k % 2), bit'(k % 3 == 0));
      ofs_access_n = 1;
      cyc(); cyc();
    end

    // R5: serial load, wrap past the last full bit, gaps in wr_en
    cur_req = "R5";
    do_reset(1, 1'b1, 1'b0);
    ofs_access_n = 0;
    for (int i = 0; i < 2 * W + 5; i++) begin
      mode_si = bit'(((i * 7 + 3) % 5) < 2);
      wr_en = (i % 6 != 5);
      cyc();
    end
    // R8: reads in serial mode leave readback at zero
    cur_req = "R8";
    wr_en = 0; rd_en = 1; cyc(); cyc();
    // R4 / R8: access closed, enables ignored
    ofs_access_n = 1; wr_en = 1; rd_en = 1; data_in = 10'h2AA; mode_si = 1;
    cyc(); cyc(); cyc();

    // R6, R7: word mode, three writes wrap, reads with own pointer
    cur_req = "R6";
    do_reset(2, 1'b0, 1'b1);
    rd_en = 0;
    for (int i = 0; i < 3; i++) begin
      wr_en = 1; data_in = W'(100 + 37 * i); cyc();
    end
    wr_en = 0;
    cur_req = "R7";
    for (int i = 0; i < 3; i++) begin rd_en = 1; cyc(); end
    wr_en = 1; data_in = 10'd555; cyc();
    rd_en = 0; wr_en = 0; cyc();
    // R8: closed access in word mode
    cur_req = "R8";
    ofs_access_n = 1; wr_en = 1; rd_en = 1; data_in = 10'd9; cyc(); cyc();

    // R9: reset mid-sequence restarts every pointer
    cur_req = "R9";
    ofs_access_n = 0; wr_en = 1; rd_en = 0; data_in = 10'd44; cyc();
    do_reset(3, 1'b0, 1'b0);
    wr_en = 1; data_in = 10'd77; cyc();
    wr_en = 0; rd_en = 1; cyc(); cyc();
    rd_en = 0;
    do_reset(0, 1'b1, 1'b1);
    ofs_access_n = 0; wr_en = 1; mode_si = 1; cyc(); cyc();

    // mixed traffic with occasional resets
    cur_req = "R5";
    begin
      int unsigned lf = 32'hACE1;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[9:4] == 0) begin
          cur_req = "R9";
          do_reset(int'(lf[3:2]), lf[12], lf[13]);
        end else begin
          cur_req = m_par ? "R6" : "R5";
          ofs_access_n = lf[5] & lf[6];
          wr_en = lf[7]; rd_en = lf[8]; mode_si = lf[10];
          data_in = W'(lf[25:16]);
          cyc();
        end
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule